// File: doc/BRIEF.md
# Circular Self-Test Ring Controller

This block wraps a state register of parameterised width around a small combinational next-state function. In normal operation the register simply captures the function's output each clock. When a test is started, the same register is closed into a ring: every cell takes the function's output for its own bit XORed with the value held by the cell before it, and the last cell feeds cell 0. The register therefore produces its own stimulus and folds the responses into a signature at the same time. It needs no separate pattern generator and no separate compactor.

A small sequencer drives the test. It first loads a seed into the ring, then runs a programmable number of self-test steps with the function's primary inputs tied to zero, then latches the ring into a signature register and pulses `done`. After that the register goes back to capturing functional data. When the sequencer is idle, a serial shift path lets a state be shifted in and the current state be shifted out. A seed that happens to enter a short loop of ring states gives a signature that repeats with the run length. Choosing seeds and run lengths is the user's task.

Top module: `cbist_ring_top`

## Requirements
- R1: While reset is held and after it is released, `state_o`, `signature`, `done` and `busy` are all zero.
- R2: When idle with `start` and `scan_en` low, each edge loads state bit i with s[(i+3) mod W] ^ (s[(i+1) mod W] & s[(i+5) mod W]) ^ sys_in[i mod P], where s is the present state, W the register width and P the input width.
- R3: When idle with `scan_en` high and `start` low, each edge shifts the state up by one bit, with `scan_in` entering bit 0. `scan_out` always equals the top state bit.
- R4: `start` seen while idle makes `busy` rise on the next edge. The edge after that loads `seed` into the state.
- R5: Each self-test step sets bit i to the R2 function with all inputs forced to zero, XORed with the previous value of bit i-1. Bit 0 takes the previous top bit. `sys_in` has no effect during the run.
- R6: A run performs exactly `run_len` steps, with `run_len` sampled together with `start`. `done` is first seen run_len+3 sampling points after `start` is driven. A `run_len` of 0 gives a signature equal to the seed.
- R7: `done` is high for exactly one cycle. `signature` takes the ring value on that same edge and holds it until the next `done`.
- R8: `start` and `scan_en` are ignored while `busy` is high.
- R9: When `start` and `scan_en` are both high in an idle cycle, `start` wins: that edge performs the R2 capture, not a shift.
- R10: On the edge after `done` rises, the state captures the R2 function of the signature and the current `sys_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_in | input | P | Primary inputs of the logic under test |
| start | input | 1 | Begin a self-test sequence (idle only) |
| run_len | input | CW | Number of self-test steps |
| seed | input | W | Initial ring value loaded at test start |
| scan_en | input | 1 | Serial shift enable (idle only) |
| scan_in | input | 1 | Serial data into bit 0 |
| scan_out | output | 1 | Serial data from the top bit |
| state_o | output | W | Present register contents |
| busy | output | 1 | Sequencer is not idle |
| done | output | 1 | One-cycle pulse when the signature is latched |
| signature | output | W | Last latched signature |

## Verification
Two functions can fall in the same cycle. A serial shift request and a test start can arrive in the same idle cycle. A fresh start or shift can also arrive at the very cycle the sequencer leaves readout. The bench drives `start` and `scan_en` together in one idle cycle and checks that the state shows a functional capture, not a shift. It also holds both requests high during whole runs and checks that the cycle count and the signature still match the software model of the ring.

// File: rtl/cbist_pkg.sv
package cbist_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_INIT,
        ST_RUN,
        ST_READ
    } ctl_state_e;

    typedef enum logic [2:0] {
        M_SYS,
        M_SCAN,
        M_LOAD,
        M_BIST,
        M_HOLD
    } ring_mode_e;

endpackage

// File: rtl/cbist_cut.sv
module cbist_cut #(
    parameter int W     = 8,
    parameter int P     = 4,
    parameter int TAP_A = 3,
    parameter int TAP_B = 1,
    parameter int TAP_C = 5
) (
    input  logic [W-1:0] state_i,
    input  logic [P-1:0] pi_i,
    output logic [W-1:0] next_o
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int IA = (i + TAP_A) % W;
        localparam int IB = (i + TAP_B) % W;
        localparam int IC = (i + TAP_C) % W;
        localparam int IP = i % P;
        assign next_o[i] = state_i[IA] ^ (state_i[IB] & state_i[IC]) ^ pi_i[IP];
    end

endmodule

// File: rtl/cbist_ring.sv
module cbist_ring
    import cbist_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  ring_mode_e    mode_i,
    input  logic [W-1:0]  fn_i,
    input  logic [W-1:0]  seed_i,
    input  logic          scan_in_i,
    output logic [W-1:0]  ring_o
);

    typedef struct packed {
        logic [W-1:0] ring;
    } ring_regs_t;

    ring_regs_t r_d, r_q;
    logic [W-1:0] prev_cell;

    assign prev_cell = {r_q.ring[W-2:0], r_q.ring[W-1]};

    always_comb begin
        r_d = r_q;
        unique case (mode_i)
            M_SYS:   r_d.ring = fn_i;
            M_SCAN:  r_d.ring = {r_q.ring[W-2:0], scan_in_i};
            M_LOAD:  r_d.ring = seed_i;
            M_BIST:  r_d.ring = fn_i ^ prev_cell;
            default: r_d.ring = r_q.ring;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign ring_o = r_q.ring;

    assert_seed_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == M_LOAD |=> r_q.ring == $past(seed_i));

    assert_scan_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == M_SCAN |=> r_q.ring[0] == $past(scan_in_i));

    assert_scan_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == M_SCAN |=> r_q.ring[W-1:1] == $past(r_q.ring[W-2:0]));

    assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i == M_HOLD |=> $stable(r_q.ring));

endmodule

// File: rtl/cbist_ctrl.sv
module cbist_ctrl
    import cbist_pkg::*;
#(
    parameter int W  = 8,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          scan_en_i,
    input  logic [CW-1:0] run_len_i,
    input  logic [W-1:0]  ring_i,
    output ring_mode_e    mode_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [W-1:0]  sig_o
);

    typedef struct packed {
        ctl_state_e    state;
        logic [CW-1:0] cnt;
        logic [W-1:0]  sig;
        logic          done;
    } ctl_regs_t;

    ctl_regs_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        mode_o   = M_SYS;
        unique case (c_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.state = ST_INIT;
                    c_d.cnt   = run_len_i;
                end else if (scan_en_i) begin
                    mode_o = M_SCAN;
                end
            end
            ST_INIT: begin
                mode_o    = M_LOAD;
                c_d.state = (c_q.cnt == '0) ? ST_READ : ST_RUN;
            end
            ST_RUN: begin
                mode_o  = M_BIST;
                c_d.cnt = c_q.cnt - CW'(1);
                if (c_q.cnt == CW'(1)) c_d.state = ST_READ;
            end
            ST_READ: begin
                mode_o    = M_HOLD;
                c_d.sig   = ring_i;
                c_d.done  = 1'b1;
                c_d.state = ST_IDLE;
            end
            default: c_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.state <= ST_IDLE;
            c_q.cnt   <= '0;
            c_q.sig   <= '0;
            c_q.done  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy_o = (c_q.state != ST_IDLE);
    assign done_o = c_q.done;
    assign sig_o  = c_q.sig;

    assert_start_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.state == ST_IDLE && start_i) |=> c_q.state == ST_INIT);

    assert_busy_ignores_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.state != ST_IDLE |=> c_q.state != ST_INIT);

    assert_run_count_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.state == ST_RUN |-> c_q.cnt != '0);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |=> !c_q.done);

    assert_done_from_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.done |-> $past(c_q.state) == ST_READ);

    assert_sig_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.state != ST_READ |=> $stable(c_q.sig));

endmodule

// File: rtl/cbist_ring_top.sv
module cbist_ring_top
    import cbist_pkg::*;
#(
    parameter int W  = 8,
    parameter int P  = 4,
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [P-1:0]  sys_in,
    input  logic          start,
    input  logic [CW-1:0] run_len,
    input  logic [W-1:0]  seed,
    input  logic          scan_en,
    input  logic          scan_in,
    output logic          scan_out,
    output logic [W-1:0]  state_o,
    output logic          busy,
    output logic          done,
    output logic [W-1:0]  signature
);

    localparam logic [P-1:0] PI_FORCE = '0;

    ring_mode_e   mode;
    logic [W-1:0] ring;
    logic [W-1:0] fn;
    logic [P-1:0] pi_eff;

    assign pi_eff = (mode == M_BIST) ? PI_FORCE : sys_in;

    cbist_cut #(.W(W), .P(P)) u_cut (
        .state_i (ring),
        .pi_i    (pi_eff),
        .next_o  (fn)
    );

    cbist_ring #(.W(W)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode),
        .fn_i      (fn),
        .seed_i    (seed),
        .scan_in_i (scan_in),
        .ring_o    (ring)
    );

    cbist_ctrl #(.W(W), .CW(CW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start),
        .scan_en_i (scan_en),
        .run_len_i (run_len),
        .ring_i    (ring),
        .mode_o    (mode),
        .busy_o    (busy),
        .done_o    (done),
        .sig_o     (signature)
    );

    assign scan_out = ring[W-1];
    assign state_o  = ring;

    assert_forced_inputs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mode == M_BIST |-> pi_eff == PI_FORCE);

endmodule

// File: tb/cbist_ring_top_tb_top.sv
module cbist_ring_top_tb_top;

    localparam int W  = 8;
    localparam int P  = 4;
    localparam int CW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [P-1:0]  sys_in = '0;
    logic          start = 1'b0;
    logic [CW-1:0] run_len = '0;
    logic [W-1:0]  seed = '0;
    logic          scan_en = 1'b0;
    logic          scan_in = 1'b0;
    logic          scan_out;
    logic [W-1:0]  state_o;
    logic          busy;
    logic          done;
    logic [W-1:0]  signature;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    cbist_ring_top #(.W(W), .P(P), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .sys_in(sys_in), .start(start),
        .run_len(run_len), .seed(seed), .scan_en(scan_en), .scan_in(scan_in),
        .scan_out(scan_out), .state_o(state_o), .busy(busy), .done(done),
        .signature(signature)
    );

    function automatic logic [W-1:0] f_cut(logic [W-1:0] s, logic [P-1:0] pi);
        logic [W-1:0] d;
        for (int i = 0; i < W; i++)
            d[i] = s[(i+3)%W] ^ (s[(i+1)%W] & s[(i+5)%W]) ^ pi[i%P];
        return d;
    endfunction

    function automatic logic [W-1:0] f_bist(logic [W-1:0] s);
        return f_cut(s, '0) ^ {s[W-2:0], s[W-1]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // One self-test run; noisy drives start/scan_en/sys_in during the run (R8, R5)
    task automatic run_test(input logic [W-1:0] sd, input int len, input bit noisy);
        logic [W-1:0] exp_sig = sd;
        int k = 0;
        logic [P-1:0] tail_in;
        for (int j = 0; j < len; j++) exp_sig = f_bist(exp_sig);
        @(negedge clk);
        seed = sd; run_len = CW'(len); start = 1'b1; scan_en = 1'b0;
        @(negedge clk);
        k = 1;
        chk(busy === 1'b1, "R4 busy", 32'(busy), 1);
        start = noisy; scan_en = noisy;
        while (done !== 1'b1 && k < len + 10) begin
            @(negedge clk);
            k++;
            if (k == 2) chk(state_o === sd, "R4 seed", 32'(state_o), 32'(sd));
            if (noisy && done !== 1'b1) begin
                seed = W'($urandom); sys_in = P'($urandom);
                start = 1'($urandom); scan_en = 1'($urandom); scan_in = 1'($urandom);
            end
        end
        start = 1'b0; scan_en = 1'b0;
        tail_in = P'($urandom);
        sys_in = tail_in;
        chk(k == len + 3, "R6 cycles", 32'(k), 32'(len + 3));
        chk(signature === exp_sig, "R5 signature", 32'(signature), 32'(exp_sig));
        @(negedge clk);
        chk(done === 1'b0, "R7 pulse", 32'(done), 0);
        chk(busy === 1'b0, "R7 idle", 32'(busy), 0);
        chk(signature === exp_sig, "R7 hold", 32'(signature), 32'(exp_sig));
        chk(state_o === f_cut(exp_sig, tail_in), "R10 resume", 32'(state_o),
            32'(f_cut(exp_sig, tail_in)));
    endtask

    initial begin
        logic [W-1:0] prev;
        logic [W-1:0] pat;
        void'($urandom(32'd1234));
        @(negedge clk);
        chk(state_o === '0 && signature === '0 && done === 1'b0 && busy === 1'b0,
            "R1 in reset", 32'({state_o, signature}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(signature === '0 && done === 1'b0 && busy === 1'b0, "R1 after reset",
            32'({signature, done, busy}), 0);

        // R3: shift in a pattern, watch scan_out
        pat = 8'hB5;
        for (int i = W - 1; i >= 0; i--) begin
            scan_en = 1'b1; scan_in = pat[i];
            @(negedge clk);
        end
        scan_en = 1'b0;
        chk(state_o === pat, "R3 shift in", 32'(state_o), 32'(pat));
        chk(scan_out === pat[W-1], "R3 scan_out", 32'(scan_out), 32'(pat[W-1]));

        // R2: random functional capture
        for (int i = 0; i < 20; i++) begin
            prev = state_o;
            sys_in = P'($urandom);
            @(negedge clk);
            chk(state_o === f_cut(prev, sys_in), "R2 capture", 32'(state_o),
                32'(f_cut(prev, sys_in)));
        end

        // R9: start and scan_en together; start wins, capture not shift
        prev = state_o;
        sys_in = 4'h9; scan_in = 1'b1; scan_en = 1'b1; start = 1'b1;
        seed = 8'h3C; run_len = CW'(2);
        @(negedge clk);
        start = 1'b0; scan_en = 1'b0;
        chk(state_o === f_cut(prev, 4'h9), "R9 start wins", 32'(state_o),
            32'(f_cut(prev, 4'h9)));
        while (done !== 1'b1) @(negedge clk);
        chk(signature === f_bist(f_bist(8'h3C)), "R9 run", 32'(signature),
            32'(f_bist(f_bist(8'h3C))));
        @(negedge clk);

        // R6 corners
        run_test(8'hA7, 0, 1'b0);
        chk(signature === 8'hA7, "R6 zero length", 32'(signature), 32'hA7);
        run_test(8'h01, 1, 1'b0);
        run_test(8'h00, 5, 1'b0);
        run_test(8'hFF, 300, 1'b0);

        // R8 / R5: noisy runs
        for (int i = 0; i < 6; i++) run_test(W'($urandom), 1 + int'($urandom % 40), 1'b1);
        // random clean runs
        for (int i = 0; i < 6; i++) run_test(W'($urandom), int'($urandom % 60), 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule